// File: doc/BRIEF.md
# Vectored Exception Entry Controller

This block decides, once per clock, whether the core enters a handler, and in the same edge computes the handler address and every piece of saved state that the entry changes. Level-sensitive request lines are sampled into a pending field. That field is gated by a per-line enable mask and by the current interrupt-enable and debug-state bits. The highest-numbered surviving line selects a vectored entry point. A synchronous exception, reported with a 6-bit cause, always takes precedence over an interrupt in the same cycle.

Three save sets exist, and each entry writes only its own. Ordinary exceptions and interrupts write the status cause, the saved mode and the return address. TLB-refill exceptions write the refill saved mode and the refill return word, and switch translation to direct mode. Debug entries write the debug return address and the debug status bits. The core supplies its current mode and the entry bases. It uses `taken_o`, `entry_kind_o` and `new_pc_o` to redirect fetch, and the registered mode outputs as the next mode. When no entry happens, the mode outputs copy the current inputs.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Each cycle, bit k of `irq_i` is stored into bit k of `pend_o` at the next edge. `hard_irq_o` is 1 whenever any bit of `pend_o` is set.
- R2: An interrupt is taken only when all four of these hold: `cur_ie_i`=1, `cur_dst_i`=0, (`pend_o` AND `lie_i`) is non-zero, and `exc_valid_i`=0.
- R3: Among the masked pending lines, the one with the highest index selects the vector.
- R4: The stride is 0 when `vs_i`=0, and 4·2^`vs_i` bytes otherwise. An interrupt entry sets `new_pc_o` = `eentry_i` + (IRQ_BASE + index)·stride, with IRQ_BASE=64 by default. It also writes `ecode_o`=0, `pplv_o`/`pie_o` = current PLV/IE, and `era_o` = `pc_i`. `entry_kind_o` encodes the entry type: 0 ordinary exception, 1 interrupt, 2 refill, 3 debug.
- R5: An ordinary exception (`exc_valid_i`=1, `tlb_refill_i`=0, and a cause other than 0 or 0x1A) sets `ecode_o`=cause, saves PLV/IE into `pplv_o`/`pie_o`, sets `era_o`=`pc_i`, and sets `new_pc_o` = `eentry_i` + cause·stride.
- R6: For an ordinary exception, `badv_o` receives `pc_i` only when the cause is one of 0x0A, 0x0B, 0x0C, 0x0D, 0x0E or 0x12. Any other cause leaves `badv_o` unchanged.
- R7: A refill exception (`tlb_refill_i`=1, with a cause other than 0 or 0x1A) saves PLV/IE into `tlbr_pplv_o`/`tlbr_pie_o` and sets `tlbr_era_o` = `pc_i`>>2. It forces `da_o`=1 and `pg_o`=0, sets `new_pc_o`=`tlbr_entry_i`, and leaves `era_o` and `ecode_o` unchanged.
- R8: Cause 0x1A (debug breakpoint) sets `dcl_o`=1, `dbg_ecode_o`=0x0C, `dera_o`=`pc_i` and `dst_o`=1, and sets `new_pc_o` = `eentry_i`+0x480.
- R9: Cause 0 with `exc_valid_i`=1 is a delivered interrupt. With `cur_dst_i`=1 it sets `dei_o`=1 and follows the debug path of R8, without touching `dcl_o` or `dbg_ecode_o`. With `cur_dst_i`=0 it is an interrupt entry as in R4.
- R10: On every entry, `taken_o` pulses for one cycle and `plv_o`=0 and `ie_o`=0. With no entry, `plv_o`, `ie_o`, `da_o`, `pg_o` and `dst_o` copy the current inputs.
- R11: A synchronous exception in the same cycle as an enabled pending interrupt wins: the entry is of the exception's kind.
- R12: After reset, `pend_o`=0, `taken_o`=0, `plv_o`=0, `ie_o`=0, `da_o`=1, `pg_o`=0 and `dst_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 13 | Level interrupt request lines |
| lie_i | input | 13 | Per-line interrupt enable mask |
| vs_i | input | 3 | Vector spacing exponent |
| cur_plv_i | input | 2 | Current privilege level |
| cur_ie_i | input | 1 | Current global interrupt enable |
| cur_da_i | input | 1 | Current direct-address mode bit |
| cur_pg_i | input | 1 | Current paging bit |
| cur_dst_i | input | 1 | Currently in debug state |
| exc_valid_i | input | 1 | Synchronous exception this cycle |
| exc_cause_i | input | 6 | Exception cause code |
| tlb_refill_i | input | 1 | Exception is a TLB refill |
| pc_i | input | 32 | PC of the faulting or interrupted instruction |
| eentry_i | input | 32 | Ordinary and debug entry base |
| tlbr_entry_i | input | 32 | Refill entry address |
| hard_irq_o | output | 1 | Some pending bit is set |
| pend_o | output | 13 | Pending field |
| taken_o | output | 1 | Entry performed at the last edge |
| entry_kind_o | output | 2 | 0 exception, 1 interrupt, 2 refill, 3 debug |
| new_pc_o | output | 32 | Handler address |
| plv_o | output | 2 | Next privilege level |
| ie_o | output | 1 | Next interrupt enable |
| da_o | output | 1 | Next direct-address bit |
| pg_o | output | 1 | Next paging bit |
| ecode_o | output | 6 | Status cause code |
| pplv_o | output | 2 | Saved privilege level |
| pie_o | output | 1 | Saved interrupt enable |
| era_o | output | 32 | Return address |
| badv_o | output | 32 | Bad address |
| tlbr_pplv_o | output | 2 | Refill saved privilege level |
| tlbr_pie_o | output | 1 | Refill saved interrupt enable |
| tlbr_era_o | output | 32 | Refill return word (PC>>2) |
| dera_o | output | 32 | Debug return address |
| dst_o | output | 1 | Next debug-state bit |
| dcl_o | output | 1 | Debug breakpoint flag |
| dei_o | output | 1 | Debug interrupt flag |
| dbg_ecode_o | output | 6 | Debug cause code |

## Verification
Interrupt entry is exercised with one pending line and with several at once. Several lines show whether the highest index wins rather than the lowest. The same requests are repeated with different spacing exponents, including zero, to separate a correct shift from a fixed stride. The gating cases each withhold exactly one condition: enable low, debug state set, or mask clear. Exceptions are driven with causes inside and outside the bad-address list, with and without the refill flag, and with the breakpoint cause. This shows that each entry writes only its own save set. Cause 0 is driven both inside and outside debug state to separate the two interrupt paths.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CAUSE_W = 6;

  typedef enum logic [1:0] {
    KIND_EXC    = 2'd0,
    KIND_INT    = 2'd1,
    KIND_REFILL = 2'd2,
    KIND_DEBUG  = 2'd3
  } entry_kind_e;

  localparam logic [CAUSE_W-1:0] CAUSE_INT = 6'h00;
  localparam logic [CAUSE_W-1:0] CAUSE_BCE = 6'h0A;
  localparam logic [CAUSE_W-1:0] CAUSE_SYS = 6'h0B;
  localparam logic [CAUSE_W-1:0] CAUSE_BRK = 6'h0C;
  localparam logic [CAUSE_W-1:0] CAUSE_INE = 6'h0D;
  localparam logic [CAUSE_W-1:0] CAUSE_IPE = 6'h0E;
  localparam logic [CAUSE_W-1:0] CAUSE_FPE = 6'h12;
  localparam logic [CAUSE_W-1:0] CAUSE_DBP = 6'h1A;
  localparam logic [CAUSE_W-1:0] DBG_BP_CODE = 6'h0C;
  localparam int unsigned DBG_VEC_OFFSET = 32'h480;

  // causes whose faulting PC is also recorded as the bad address
  function automatic logic records_badv(input logic [CAUSE_W-1:0] c);
    return (c == CAUSE_BCE) || (c == CAUSE_SYS) || (c == CAUSE_BRK) ||
           (c == CAUSE_INE) || (c == CAUSE_IPE) || (c == CAUSE_FPE);
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_IRQ = 13,
  parameter int IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] lie_i,
  output logic [N_IRQ-1:0] pend_o,
  output logic             any_pend_o,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o
);
  logic [N_IRQ-1:0] masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= irq_i;
  end

  assign any_pend_o = |pend_o;
  assign masked     = pend_o & lie_i;

  // later (higher) indices overwrite earlier ones
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    for (int k = 0; k < N_IRQ; k++) begin
      if (masked[k]) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(k);
      end
    end
  end

  a_r1_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend_o == $past(irq_i));

  a_r3_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> (masked[win_idx_o] && ((masked >> win_idx_o) == N_IRQ'(1))));
endmodule

// File: rtl/vec_offset.sv
module vec_offset #(
  parameter int PC_W   = 32,
  parameter int CODE_W = 7,
  parameter int VS_W   = 3
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [VS_W-1:0]   vs_i,
  output logic [PC_W-1:0]   off_o
);
  logic [VS_W:0] sh;

  // stride = 4 << vs, so offset = code << (vs + 2)
  assign sh    = {1'b0, vs_i} + (VS_W+1)'(2);
  assign off_o = (vs_i == '0) ? '0 : (PC_W'(code_i) << sh);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int N_IRQ    = 13,
  parameter int PC_W     = 32,
  parameter int VS_W     = 3,
  parameter int IRQ_BASE = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic [N_IRQ-1:0]   lie_i,
  input  logic [VS_W-1:0]    vs_i,
  input  logic [1:0]         cur_plv_i,
  input  logic               cur_ie_i,
  input  logic               cur_da_i,
  input  logic               cur_pg_i,
  input  logic               cur_dst_i,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               tlb_refill_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    eentry_i,
  input  logic [PC_W-1:0]    tlbr_entry_i,
  output logic               hard_irq_o,
  output logic [N_IRQ-1:0]   pend_o,
  output logic               taken_o,
  output logic [1:0]         entry_kind_o,
  output logic [PC_W-1:0]    new_pc_o,
  output logic [1:0]         plv_o,
  output logic               ie_o,
  output logic               da_o,
  output logic               pg_o,
  output logic [CAUSE_W-1:0] ecode_o,
  output logic [1:0]         pplv_o,
  output logic               pie_o,
  output logic [PC_W-1:0]    era_o,
  output logic [PC_W-1:0]    badv_o,
  output logic [1:0]         tlbr_pplv_o,
  output logic               tlbr_pie_o,
  output logic [PC_W-1:0]    tlbr_era_o,
  output logic [PC_W-1:0]    dera_o,
  output logic               dst_o,
  output logic               dcl_o,
  output logic               dei_o,
  output logic [CAUSE_W-1:0] dbg_ecode_o
);
  localparam int IDX_W  = $clog2(N_IRQ);
  localparam int RAW_W  = $clog2(IRQ_BASE + N_IRQ + 1);
  localparam int CODE_W = (RAW_W > CAUSE_W) ? RAW_W : CAUSE_W;

  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [CODE_W-1:0] vec_code;
  logic [PC_W-1:0]  vec_off;
  logic [PC_W-1:0]  target_pc;
  logic cause_int, cause_dbp;
  logic dbg_path, bp_path, dei_path, irq_path, refill_path, exc_path, take;
  entry_kind_e kind;

  irq_pick #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_i      (irq_i),
    .lie_i      (lie_i),
    .pend_o     (pend_o),
    .any_pend_o (hard_irq_o),
    .win_vld_o  (win_vld),
    .win_idx_o  (win_idx)
  );

  // path selection: synchronous exception first, then interrupts
  always_comb begin
    cause_int   = (exc_cause_i == CAUSE_INT);
    cause_dbp   = (exc_cause_i == CAUSE_DBP);
    bp_path     = exc_valid_i && cause_dbp;
    dei_path    = exc_valid_i && cause_int && cur_dst_i;
    dbg_path    = bp_path || dei_path;
    irq_path    = (exc_valid_i && cause_int && !cur_dst_i) ||
                  (!exc_valid_i && cur_ie_i && !cur_dst_i && win_vld);
    refill_path = exc_valid_i && tlb_refill_i && !cause_int && !cause_dbp;
    exc_path    = exc_valid_i && !tlb_refill_i && !cause_int && !cause_dbp;
    take        = exc_valid_i || irq_path;
    if (dbg_path)         kind = KIND_DEBUG;
    else if (refill_path) kind = KIND_REFILL;
    else if (irq_path)    kind = KIND_INT;
    else                  kind = KIND_EXC;
  end

  assign vec_code = irq_path ? (CODE_W'(IRQ_BASE) + CODE_W'(win_idx))
                             : CODE_W'(exc_cause_i);

  vec_offset #(.PC_W(PC_W), .CODE_W(CODE_W), .VS_W(VS_W)) u_off (
    .code_i (vec_code),
    .vs_i   (vs_i),
    .off_o  (vec_off)
  );

  always_comb begin
    if (dbg_path)         target_pc = eentry_i + PC_W'(DBG_VEC_OFFSET);
    else if (refill_path) target_pc = tlbr_entry_i;
    else                  target_pc = eentry_i + vec_off;
  end

  // mode and entry flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_o      <= 1'b0;
      entry_kind_o <= KIND_EXC;
      new_pc_o     <= '0;
      plv_o        <= '0;
      ie_o         <= 1'b0;
      da_o         <= 1'b1;
      pg_o         <= 1'b0;
      dst_o        <= 1'b0;
    end else begin
      taken_o      <= take;
      entry_kind_o <= kind;
      if (take) new_pc_o <= target_pc;
      plv_o <= take ? 2'd0 : cur_plv_i;
      ie_o  <= take ? 1'b0 : cur_ie_i;
      da_o  <= refill_path ? 1'b1 : cur_da_i;
      pg_o  <= refill_path ? 1'b0 : cur_pg_i;
      dst_o <= dbg_path ? 1'b1 : cur_dst_i;
    end
  end

  // ordinary / interrupt save set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecode_o <= '0;
      pplv_o  <= '0;
      pie_o   <= 1'b0;
      era_o   <= '0;
      badv_o  <= '0;
    end else begin
      if (exc_path || irq_path) begin
        ecode_o <= irq_path ? CAUSE_INT : exc_cause_i;
        pplv_o  <= cur_plv_i;
        pie_o   <= cur_ie_i;
        era_o   <= pc_i;
      end
      if (exc_path && records_badv(exc_cause_i)) badv_o <= pc_i;
    end
  end

  // refill and debug save sets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tlbr_pplv_o <= '0;
      tlbr_pie_o  <= 1'b0;
      tlbr_era_o  <= '0;
      dera_o      <= '0;
      dcl_o       <= 1'b0;
      dei_o       <= 1'b0;
      dbg_ecode_o <= '0;
    end else begin
      if (refill_path) begin
        tlbr_pplv_o <= cur_plv_i;
        tlbr_pie_o  <= cur_ie_i;
        tlbr_era_o  <= pc_i >> 2;
      end
      if (dbg_path) dera_o <= pc_i;
      if (bp_path) begin
        dcl_o       <= 1'b1;
        dbg_ecode_o <= DBG_BP_CODE;
      end
      if (dei_path) dei_o <= 1'b1;
    end
  end

  a_r10_mode_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (plv_o == 2'd0 && !ie_o));

  a_r7_refill_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && entry_kind_o == KIND_REFILL) |->
      (da_o && !pg_o && tlbr_era_o == ($past(pc_i) >> 2) &&
       new_pc_o == $past(tlbr_entry_i)));

  a_r8_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && entry_kind_o == KIND_DEBUG) |-> (dst_o && dera_o == $past(pc_i)));

  a_r11_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(exc_valid_i) && $past(exc_cause_i) != CAUSE_INT) |->
      !(taken_o && entry_kind_o == KIND_INT));

  a_r2_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && entry_kind_o == KIND_INT && !$past(exc_valid_i)) |->
      ($past(cur_ie_i) && !$past(cur_dst_i)));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq_i = '0, lie_i = '0;
  logic [2:0]  vs_i = '0;
  logic [1:0]  cur_plv_i = '0;
  logic        cur_ie_i = 0, cur_da_i = 1, cur_pg_i = 0, cur_dst_i = 0;
  logic        exc_valid_i = 0, tlb_refill_i = 0;
  logic [5:0]  exc_cause_i = '0;
  logic [31:0] pc_i = '0, eentry_i = 32'h1000_0000, tlbr_entry_i = 32'h2000_0000;
  logic        hard_irq_o, taken_o, ie_o, da_o, pg_o, pie_o, tlbr_pie_o;
  logic        dst_o, dcl_o, dei_o;
  logic [12:0] pend_o;
  logic [1:0]  entry_kind_o, plv_o, pplv_o, tlbr_pplv_o;
  logic [5:0]  ecode_o, dbg_ecode_o;
  logic [31:0] new_pc_o, era_o, badv_o, tlbr_era_o, dera_o;

  int checks = 0, errors = 0;
  bit done = 0;

  exc_entry_ctrl dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic longint voff(input int code, input int vs);
    return (vs == 0) ? 0 : longint'(code) * (4 * (1 << vs));
  endfunction

  task automatic cyc(); @(negedge clk); endtask

  task automatic t_reset();
    chk("R12 pend", pend_o, 0);
    chk("R12 taken", taken_o, 0);
    chk("R12 plv/ie", {plv_o, ie_o}, 0);
    chk("R12 da/pg/dst", {da_o, pg_o, dst_o}, 3'b100);
  endtask

  task automatic t_pending();
    irq_i = 13'h1005; cyc();
    chk("R1 pend", pend_o, 13'h1005);
    chk("R1 hard_irq", hard_irq_o, 1);
    irq_i = '0; cyc();
    chk("R1 clear", hard_irq_o, 0);
  endtask

  task automatic t_gate();
    irq_i = 13'h0008; lie_i = 13'h0008; cyc();
    cur_ie_i = 1; cur_dst_i = 1; cyc();
    chk("R2 dst blocks", taken_o, 0);
    cur_dst_i = 0; lie_i = 0; cyc();
    chk("R2 mask blocks", taken_o, 0);
    cur_ie_i = 0; lie_i = 13'h0008; cyc();
    chk("R2 ie blocks", taken_o, 0);
    cur_plv_i = 2'd3; cur_ie_i = 1; pc_i = 32'h400; vs_i = 3'd1; cyc();
    cur_ie_i = 0;
    chk("R2 taken", taken_o, 1);
    chk("R4 kind", entry_kind_o, 1);
    chk("R4 pc", new_pc_o, 32'h1000_0000 + voff(64 + 3, 1));
    chk("R4 save", {ecode_o, pplv_o, pie_o}, {6'd0, 2'd3, 1'b1});
    chk("R4 era", era_o, 32'h400);
    chk("R10 mode", {plv_o, ie_o}, 0);
    irq_i = 0; cur_plv_i = 0; cyc();
    chk("R10 one pulse", taken_o, 0);
  endtask

  task automatic t_priority(input logic [12:0] lines, input logic [12:0] mask,
                            input int vs, input int exp_idx);
    irq_i = lines; lie_i = mask; vs_i = 3'(vs); cyc();
    cur_ie_i = 1; cyc(); cur_ie_i = 0;
    chk("R3 winner pc", new_pc_o, 32'h1000_0000 + voff(64 + exp_idx, vs));
    irq_i = 0; cyc();
  endtask

  task automatic t_exc_badv();
    cur_plv_i = 2'd2; cur_ie_i = 0; vs_i = 3'd2;
    exc_valid_i = 1; exc_cause_i = 6'h0B; pc_i = 32'h8000; cyc();
    exc_valid_i = 0;
    chk("R5 kind", entry_kind_o, 0);
    chk("R5 ecode", ecode_o, 6'h0B);
    chk("R5 pc", new_pc_o, 32'h1000_0000 + voff(11, 2));
    chk("R6 badv set", badv_o, 32'h8000);
    exc_valid_i = 1; exc_cause_i = 6'h05; pc_i = 32'h9000; cyc();
    exc_valid_i = 0;
    chk("R5 era", era_o, 32'h9000);
    chk("R5 pplv", pplv_o, 2);
    chk("R6 badv kept", badv_o, 32'h8000);
    vs_i = 0; exc_valid_i = 1; exc_cause_i = 6'h07; cyc(); exc_valid_i = 0;
    chk("R4 stride zero", new_pc_o, 32'h1000_0000);
    cur_plv_i = 0; cyc();
  endtask

  task automatic t_refill();
    cur_plv_i = 2'd1; cur_ie_i = 1; cur_da_i = 0; cur_pg_i = 1;
    exc_valid_i = 1; tlb_refill_i = 1; exc_cause_i = 6'h01; pc_i = 32'hABC0; cyc();
    exc_valid_i = 0; tlb_refill_i = 0; cur_ie_i = 0;
    chk("R7 pc", new_pc_o, 32'h2000_0000);
    chk("R7 kind", entry_kind_o, 2);
    chk("R7 save", {tlbr_pplv_o, tlbr_pie_o}, 3'b011);
    chk("R7 era word", tlbr_era_o, 32'hABC0 >> 2);
    chk("R7 da/pg", {da_o, pg_o}, 2'b10);
    chk("R7 era untouched", era_o, 32'h9000);
    chk("R7 ecode untouched", ecode_o, 6'h07);
    cyc();
    chk("R10 follows", {plv_o, da_o, pg_o}, {2'd1, 1'b0, 1'b1});
    cur_plv_i = 0; cur_da_i = 1; cur_pg_i = 0; cyc();
  endtask

  task automatic t_debug();
    exc_valid_i = 1; exc_cause_i = 6'h1A; pc_i = 32'h5550; cyc();
    exc_valid_i = 0;
    chk("R8 pc", new_pc_o, 32'h1000_0480);
    chk("R8 bits", {dst_o, dcl_o, dei_o, dbg_ecode_o}, {1'b1, 1'b1, 1'b0, 6'h0C});
    chk("R8 dera", dera_o, 32'h5550);
    chk("R8 era untouched", era_o, 32'h9000);
    cur_dst_i = 1; exc_valid_i = 1; exc_cause_i = 6'h00; pc_i = 32'h7770; cyc();
    exc_valid_i = 0;
    chk("R9 debug kind", entry_kind_o, 3);
    chk("R9 dei", dei_o, 1);
    chk("R9 dera", dera_o, 32'h7770);
    cur_dst_i = 0; cyc();
    chk("R10 dst follows", dst_o, 0);
    irq_i = 13'h0030; lie_i = 13'h1FFF; vs_i = 3'd3; cyc();
    exc_valid_i = 1; exc_cause_i = 6'h00; pc_i = 32'h1110; cyc();
    exc_valid_i = 0;
    chk("R9 delivered int", entry_kind_o, 1);
    chk("R9 delivered pc", new_pc_o, 32'h1000_0000 + voff(64 + 5, 3));
    irq_i = 0; cyc();
  endtask

  task automatic t_exc_first();
    irq_i = 13'h0002; lie_i = 13'h0002; vs_i = 3'd1; cyc();
    cur_ie_i = 1; exc_valid_i = 1; exc_cause_i = 6'h09; cyc();
    cur_ie_i = 0; exc_valid_i = 0;
    chk("R11 kind", entry_kind_o, 0);
    chk("R11 ecode", ecode_o, 6'h09);
    irq_i = 0; cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    t_reset();
    t_pending();
    t_gate();
    t_priority(13'h1101, 13'h1FFF, 2, 12);
    t_priority(13'h1101, 13'h0FFF, 4, 8);
    t_priority(13'h0003, 13'h1FFF, 0, 1);
    t_exc_badv();
    t_refill();
    t_debug();
    t_exc_first();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule